// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Idle-Line Detection and Loop Routing

The block is a byte-wide asynchronous serial transceiver. A transmitter takes a parallel byte through a valid/ready handshake and shifts it out as a ten-bit frame. A receiver oversamples the incoming line, rebuilds the character and reports it with parity-error and framing-error flags. Both halves run from one shared oversampling tick produced by an integer clock divider.

An optional parity bit takes the top character position, with even or odd polarity. The transmitter generates the parity and the receiver checks it. A separate detector pulses when the line has stayed high for a whole character time. Its count can start right after a start bit or only after a complete frame; the second choice keeps a run of trailing ones inside a frame from being mistaken for idle.

A routing selector decides what the receiver listens to. It can listen to the receive pin, to the transmitter directly (internal loop, with the transmit pin parked high), or to the transmit pin itself (single wire, with the pin driver enabled only while a frame is going out). Configuration inputs are static and are changed only while both halves are quiet.

Top module: `uart_idle_loop`

## Requirements
- R1: A transmitted frame is one start bit (0), eight character bits least significant first, and one stop bit (1), each lasting 16*CLK_DIV clocks. `tx_ready` is low from the cycle after a byte is accepted until the frame ends.
- R2: With `cfg_parity_en`=1 the transmitted character bit 7 is replaced by parity over `tx_data[6:0]`. With `cfg_parity_odd`=0 (even) the parity bit is 1 exactly when those bits hold an odd count of ones; `cfg_parity_odd`=1 inverts it. `tx_data[7]` is then ignored.
- R3: Each received frame gives a one-clock `rx_valid` pulse with `rx_data` set to the eight character bits. With parity enabled, `rx_data[7]` reads 0 and `rx_data[6:0]` carries the data.
- R4: `rx_perr` is 1 on a received frame when parity is enabled and the received bit 7 differs from the parity of bits 6..0 under the selected polarity. It is always 0 when parity is disabled.
- R5: `rx_ferr` is 1 when the stop bit is sampled low; parity and framing errors can both be flagged on one frame. After a framing error the receiver waits for the line to return high before it hunts for a new start bit.
- R6: A low pulse shorter than half a bit time is rejected as a start bit and produces no frame.
- R7: With `cfg_idle_after_stop`=0, ones are counted toward idle from the end of the start bit, so data ones before the stop bit count.
- R8: With `cfg_idle_after_stop`=1, counting begins only once a frame has ended, so ones inside a frame never count.
- R9: `idle_det` pulses for one clock after 10 bit times of continuous ones. It fires at most once per received character and never before the first character after reset.
- R10: `cfg_route`=1 (internal loop) feeds the transmitter output to the receiver, ignores `rxd`, holds `txd` at 1 and `txd_oe` at 1.
- R11: `cfg_route`=2 (single wire) makes the receiver listen to `txd_pin_in`. `txd_oe` is 1 only while a frame is being transmitted.
- R12: `cfg_route`=0 (and 3) makes the receiver listen to `rxd`, drives frames on `txd`, and holds `txd_oe` at 1. Transmitted frames do not reach the receiver.
- R13: After reset `tx_ready`=1, `txd`=1, `rx_valid`=0 and `idle_det`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_parity_en | input | 1 | 1 = parity in character bit 7 |
| cfg_parity_odd | input | 1 | 0 = even parity, 1 = odd parity |
| cfg_idle_after_stop | input | 1 | 0 = idle count from after start bit, 1 = from after stop bit |
| cfg_route | input | 2 | 0/3 normal, 1 internal loop, 2 single wire |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_valid | output | 1 | One-clock pulse: received frame |
| rx_data | output | 8 | Received character |
| rx_perr | output | 1 | Parity error on this frame |
| rx_ferr | output | 1 | Framing error on this frame |
| idle_det | output | 1 | One-clock pulse: idle line detected |
| rxd | input | 1 | Receive pin |
| txd_pin_in | input | 1 | Level read back from the transmit pin |
| txd | output | 1 | Transmit pin drive value |
| txd_oe | output | 1 | Transmit pin driver enable |

## Verification
A parity error and a framing error are produced together on one received frame. This is provoked by bit-banging a character with wrong parity and a low stop bit on `rxd`. The scoreboard then expects both flags set on the same `rx_valid` pulse, and expects no phantom frame from the low line that follows. A second interaction is between idle counting and frame reception: two frames with a six-bit gap are sent after a character ending in four ones. The idle pulse must appear in the gap when counting starts after the start bit, and must not appear there when counting starts after the stop bit.

// File: rtl/uart_il_pkg.sv
package uart_il_pkg;

    typedef enum logic [1:0] {
        ROUTE_NORMAL = 2'd0,
        ROUTE_LOOP   = 2'd1,
        ROUTE_WIRE   = 2'd2,
        ROUTE_SPARE  = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_word_t;

    localparam int CHAR_BITS  = 8;
    localparam int FRAME_BITS = CHAR_BITS + 2;

    function automatic logic parity_of(input logic [CHAR_BITS-2:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic [CHAR_BITS-1:0] tx_char(input logic [CHAR_BITS-1:0] d,
                                                     input logic pe, input logic odd);
        return pe ? {parity_of(d[CHAR_BITS-2:0], odd), d[CHAR_BITS-2:0]} : d;
    endfunction

endpackage

// File: rtl/uart_il_baud.sv
module uart_il_baud #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [DW-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (div_cnt == DW'(CLK_DIV - 1)) begin
            div_cnt <= '0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            tick    <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_il_tx.sv
module uart_il_tx
    import uart_il_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    input  logic                 tx_valid,
    input  logic [CHAR_BITS-1:0] tx_data,
    output logic                 tx_ready,
    output logic                 line,
    output logic                 busy
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] frame;
    logic [BW-1:0]         bit_idx;
    logic [CW-1:0]         os_cnt;
    logic                  accept;

    assign accept   = tx_valid && !busy;
    assign tx_ready = !busy;
    assign line     = busy ? frame[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            frame   <= '1;
            bit_idx <= '0;
            os_cnt  <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            frame   <= {1'b1, tx_char(tx_data, parity_en, parity_odd), 1'b0};
            bit_idx <= '0;
            os_cnt  <= '0;
        end else if (busy && tick) begin
            if (os_cnt == CW'(OVS - 1)) begin
                os_cnt <= '0;
                frame  <= {1'b1, frame[FRAME_BITS-1:1]};
                if (bit_idx == BW'(FRAME_BITS - 1)) begin
                    busy <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end else begin
                os_cnt <= os_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_il_rx.sv
module uart_il_rx
    import uart_il_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    input  logic     parity_en,
    input  logic     parity_odd,
    output logic     done,
    output rx_word_t word,
    output logic     in_start,
    output logic     in_frame
);
    localparam int CW   = $clog2(OVS);
    localparam int MID  = OVS / 2;
    localparam int LAST = OVS - 1;
    localparam int IW   = $clog2(CHAR_BITS);

    rx_state_e            state;
    logic [CW-1:0]        os_cnt;
    logic [IW-1:0]        bit_idx;
    logic [1:0]           window;
    logic [CHAR_BITS-1:0] shreg;
    logic                 wait_high;
    logic                 maj;
    logic                 at_mid;
    logic                 at_last;

    assign maj      = vote3(window[1], window[0], line);
    assign at_mid   = (os_cnt == CW'(MID));
    assign at_last  = (os_cnt == CW'(LAST));
    assign in_start = (state == RX_START);
    assign in_frame = (state != RX_HUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_HUNT;
            os_cnt    <= '0;
            bit_idx   <= '0;
            window    <= 2'b11;
            shreg     <= '0;
            wait_high <= 1'b0;
            done      <= 1'b0;
            word      <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                window <= {window[0], line};
                if (state != RX_HUNT) begin
                    os_cnt <= at_last ? '0 : os_cnt + 1'b1;
                end
                case (state)
                    RX_HUNT: begin
                        if (line) begin
                            wait_high <= 1'b0;
                        end else if (!wait_high) begin
                            state  <= RX_START;
                            os_cnt <= CW'(1);
                        end
                    end
                    RX_START: begin
                        if (at_mid && maj) begin
                            state <= RX_HUNT;
                        end else if (at_last) begin
                            state   <= RX_DATA;
                            bit_idx <= '0;
                        end
                    end
                    RX_DATA: begin
                        if (at_mid) begin
                            shreg <= {maj, shreg[CHAR_BITS-1:1]};
                        end
                        if (at_last) begin
                            if (bit_idx == IW'(CHAR_BITS - 1)) begin
                                state <= RX_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                    RX_STOP: begin
                        if (at_mid) begin
                            done       <= 1'b1;
                            word.data  <= parity_en ? {1'b0, shreg[CHAR_BITS-2:0]} : shreg;
                            word.perr  <= parity_en &&
                                (shreg[CHAR_BITS-1] != parity_of(shreg[CHAR_BITS-2:0], parity_odd));
                            word.ferr  <= !maj;
                            wait_high  <= !maj;
                            state      <= RX_HUNT;
                        end
                    end
                    default: state <= RX_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_il_idle.sv
module uart_il_idle
    import uart_il_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    input  logic in_start,
    input  logic in_frame,
    input  logic frame_done,
    input  logic after_stop,
    output logic idle_det
);
    localparam int LIM = OVS * FRAME_BITS;
    localparam int IW  = $clog2(LIM + 1);

    logic [IW-1:0] ones_cnt;
    logic          armed;
    logic          count_en;

    assign count_en = after_stop ? !in_frame : !in_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_cnt <= '0;
            armed    <= 1'b0;
            idle_det <= 1'b0;
        end else begin
            idle_det <= 1'b0;
            if (frame_done) begin
                armed <= 1'b1;
            end
            if (tick) begin
                if (!count_en || !line) begin
                    ones_cnt <= '0;
                end else if (ones_cnt != IW'(LIM)) begin
                    ones_cnt <= ones_cnt + 1'b1;
                end
                if (count_en && line && armed && !frame_done &&
                    ones_cnt == IW'(LIM - 1)) begin
                    idle_det <= 1'b1;
                    armed    <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/uart_idle_loop.sv
module uart_idle_loop
    import uart_il_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int OVS     = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_parity_en,
    input  logic       cfg_parity_odd,
    input  logic       cfg_idle_after_stop,
    input  logic [1:0] cfg_route,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       idle_det,
    input  logic       rxd,
    input  logic       txd_pin_in,
    output logic       txd,
    output logic       txd_oe
);
    route_e   route;
    rx_word_t word;
    logic     tick;
    logic     tx_line;
    logic     tx_busy;
    logic     rx_src;
    logic     sync_a;
    logic     sync_b;
    logic     rx_done;
    logic     rx_in_start;
    logic     rx_in_frame;

    assign route = route_e'(cfg_route);

    uart_il_baud #(.CLK_DIV(CLK_DIV)) u_baud (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    uart_il_tx #(.OVS(OVS)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .parity_en (cfg_parity_en),
        .parity_odd(cfg_parity_odd),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .line      (tx_line),
        .busy      (tx_busy)
    );

    always_comb begin
        case (route)
            ROUTE_LOOP: begin
                rx_src = tx_line;
                txd    = 1'b1;
                txd_oe = 1'b1;
            end
            ROUTE_WIRE: begin
                rx_src = txd_pin_in;
                txd    = tx_line;
                txd_oe = tx_busy;
            end
            default: begin
                rx_src = rxd;
                txd    = tx_line;
                txd_oe = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= rx_src;
            sync_b <= sync_a;
        end
    end

    uart_il_rx #(.OVS(OVS)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .line      (sync_b),
        .parity_en (cfg_parity_en),
        .parity_odd(cfg_parity_odd),
        .done      (rx_done),
        .word      (word),
        .in_start  (rx_in_start),
        .in_frame  (rx_in_frame)
    );

    uart_il_idle #(.OVS(OVS)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .line      (sync_b),
        .in_start  (rx_in_start),
        .in_frame  (rx_in_frame),
        .frame_done(rx_done),
        .after_stop(cfg_idle_after_stop),
        .idle_det  (idle_det)
    );

    assign rx_valid = rx_done;
    assign rx_data  = word.data;
    assign rx_perr  = word.perr;
    assign rx_ferr  = word.ferr;
endmodule

// File: rtl/uart_idle_loop_chk.sv
module uart_idle_loop_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_parity_en,
    input logic [1:0] cfg_route,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_perr,
    input logic       idle_det,
    input logic       txd,
    input logic       txd_oe
);
    AST_TX_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready); // R1
    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R3
    AST_PE_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_parity_en) |-> !rx_data[7]); // R3
    AST_NO_PERR_UNPARITY: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_parity_en) |-> !rx_perr); // R4
    AST_IDLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        idle_det |=> !idle_det); // R9
    AST_LOOP_TXD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cfg_route == 2'd1 && !tx_ready) |-> txd); // R10
    AST_WIRE_OE_ON: assert property (@(posedge clk) disable iff (rst)
        (cfg_route == 2'd2 && tx_valid && tx_ready) |=> txd_oe); // R11
    AST_NORMAL_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_route == 2'd0 && tx_valid && tx_ready) |=> !txd); // R12
endmodule

bind uart_idle_loop uart_idle_loop_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_parity_en(cfg_parity_en),
    .cfg_route    (cfg_route),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_perr      (rx_perr),
    .idle_det     (idle_det),
    .txd          (txd),
    .txd_oe       (txd_oe)
);

// File: tb/uart_idle_loop_test.sv
module uart_idle_loop_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int OVS        = 16;
    localparam int BIT        = DIV * OVS;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0;
    logic       cfg_idle_after_stop = 1'b0;
    logic [1:0] cfg_route = 2'd0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       ext_line = 1'b1;
    logic       tx_ready, rx_valid, rx_perr, rx_ferr, idle_det, txd, txd_oe;
    logic [7:0] rx_data;
    logic       txd_pin_in;

    int checks = 0;
    int failures = 0;
    int rx_cnt = 0;
    int idle_cnt = 0;
    bit done = 1'b0;
    logic [9:0] exp_q[$];

    assign txd_pin_in = txd_oe ? txd : ext_line;

    uart_idle_loop #(.CLK_DIV(DIV), .OVS(OVS)) uut (
        .clk(clk), .rst(rst),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_idle_after_stop(cfg_idle_after_stop), .cfg_route(cfg_route),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .idle_det(idle_det), .rxd(ext_line), .txd_pin_in(txd_pin_in),
        .txd(txd), .txd_oe(txd_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: expected words are {ferr, perr, data}
    always @(negedge clk) begin
        logic [9:0] e;
        if (!rst) begin
            if (rx_valid) begin
                rx_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected frame", 32'({rx_ferr, rx_perr, rx_data}), 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check({rx_ferr, rx_perr, rx_data} == e, "R3/R4/R5 received word",
                          32'({rx_ferr, rx_perr, rx_data}), 32'(e));
                end
            end
            if (idle_det) idle_cnt++;
        end
    end

    task automatic expect_word(input logic [7:0] d, input logic pe, input logic fe);
        exp_q.push_back({fe, pe, d});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BIT) @(negedge clk);
    endtask

    task automatic send_tx(input logic [7:0] d);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
    endtask

    task automatic capture(output logic [9:0] f);
        repeat (BIT / 2) @(negedge clk);
        f[0] = txd;
        for (int i = 1; i < 10; i++) begin
            repeat (BIT) @(negedge clk);
            f[i] = txd;
        end
    endtask

    task automatic send_raw(input logic [7:0] ch, input logic stop);
        logic [9:0] b;
        b = {stop, ch, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ext_line = b[i];
            repeat (BIT - 1) @(negedge clk);
        end
        @(negedge clk);
        ext_line = 1'b1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [9:0] f;
        int n0;
        int bad;

        do_reset();
        @(negedge clk);
        check(tx_ready == 1'b1, "R13 tx_ready after reset", 32'(tx_ready), 32'h1);
        check(txd == 1'b1, "R13 txd after reset", 32'(txd), 32'h1);
        check(rx_valid == 1'b0, "R13 rx_valid after reset", 32'(rx_valid), 32'h0);
        check(idle_det == 1'b0, "R13 idle_det after reset", 32'(idle_det), 32'h0);

        // R1 / R12: normal route transmit
        n0 = rx_cnt;
        send_tx(8'hA5);
        check(!tx_ready, "R1 ready low during frame", 32'(tx_ready), 32'h0);
        check(txd_oe, "R12 oe held in normal route", 32'(txd_oe), 32'h1);
        capture(f);
        check(f == {1'b1, 8'hA5, 1'b0}, "R1 frame on txd", 32'(f), 32'({1'b1, 8'hA5, 1'b0}));
        wait_ready();
        wait_bits(1);
        check(rx_cnt == n0, "R12 no internal path in normal route", 32'(rx_cnt), 32'(n0));

        // R2: parity placement and polarity
        cfg_parity_en = 1'b1;
        cfg_parity_odd = 1'b0;
        send_tx(8'h83);
        capture(f);
        check(f == {1'b1, 8'h03, 1'b0}, "R2 even parity frame", 32'(f), 32'({1'b1, 8'h03, 1'b0}));
        wait_ready();
        cfg_parity_odd = 1'b1;
        send_tx(8'h03);
        capture(f);
        check(f == {1'b1, 8'h83, 1'b0}, "R2 odd parity frame", 32'(f), 32'({1'b1, 8'h83, 1'b0}));
        wait_ready();

        // R3 / R4 / R5: receive via rxd
        cfg_parity_en = 1'b0;
        cfg_parity_odd = 1'b0;
        expect_word(8'h3C, 1'b0, 1'b0); send_raw(8'h3C, 1'b1); wait_bits(1);
        cfg_parity_en = 1'b1;
        expect_word(8'h55, 1'b0, 1'b0); send_raw(8'h55, 1'b1); wait_bits(1);
        expect_word(8'h55, 1'b1, 1'b0); send_raw(8'hD5, 1'b1); wait_bits(1);
        cfg_parity_odd = 1'b1;
        expect_word(8'h55, 1'b0, 1'b0); send_raw(8'hD5, 1'b1); wait_bits(1);
        cfg_parity_odd = 1'b0;
        expect_word(8'h55, 1'b1, 1'b1); send_raw(8'hD5, 1'b0); wait_bits(2);
        cfg_parity_en = 1'b0;
        expect_word(8'hD5, 1'b0, 1'b0); send_raw(8'hD5, 1'b1); wait_bits(1);
        check(exp_q.size() == 0, "R5 all received words delivered", 32'(exp_q.size()), 32'h0);

        // R6: short low pulse
        n0 = rx_cnt;
        ext_line = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        ext_line = 1'b1;
        wait_bits(2);
        check(rx_cnt == n0, "R6 glitch rejected", 32'(rx_cnt), 32'(n0));

        // R10: internal loop, rxd ignored
        cfg_route = 2'd1;
        @(negedge clk);
        ext_line = 1'b0;
        expect_word(8'h5A, 1'b0, 1'b0);
        send_tx(8'h5A);
        bad = 0;
        while (!tx_ready) begin
            if (!txd || !txd_oe) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R10 txd parked high in loop", 32'(bad), 32'h0);
        wait_bits(2);
        check(exp_q.size() == 0, "R10 looped frame received", 32'(exp_q.size()), 32'h0);
        ext_line = 1'b1;

        // R7 / R9: idle counted from after start bit
        cfg_idle_after_stop = 1'b0;
        do_reset();
        idle_cnt = 0;
        wait_bits(12);
        check(idle_cnt == 0, "R9 no idle before first character", 32'(idle_cnt), 32'h0);
        expect_word(8'hF0, 1'b0, 1'b0); send_tx(8'hF0); wait_ready();
        wait_bits(6);
        expect_word(8'h11, 1'b0, 1'b0); send_tx(8'h11); wait_ready();
        wait_bits(1);
        check(idle_cnt == 1, "R7 trailing ones counted toward idle", 32'(idle_cnt), 32'h1);
        wait_bits(12);
        check(idle_cnt == 2, "R7 idle after last character", 32'(idle_cnt), 32'h2);
        wait_bits(12);
        check(idle_cnt == 2, "R9 no second idle without character", 32'(idle_cnt), 32'h2);

        // R8: idle counted from after stop bit
        cfg_idle_after_stop = 1'b1;
        do_reset();
        idle_cnt = 0;
        expect_word(8'hF0, 1'b0, 1'b0); send_tx(8'hF0); wait_ready();
        wait_bits(6);
        expect_word(8'h11, 1'b0, 1'b0); send_tx(8'h11); wait_ready();
        wait_bits(1);
        check(idle_cnt == 0, "R8 no false idle from in-frame ones", 32'(idle_cnt), 32'h0);
        wait_bits(12);
        check(idle_cnt == 1, "R8 idle after full silence", 32'(idle_cnt), 32'h1);

        // R11: single wire
        cfg_idle_after_stop = 1'b0;
        cfg_route = 2'd2;
        repeat (4) @(negedge clk);
        check(!txd_oe, "R11 driver off when quiet", 32'(txd_oe), 32'h0);
        expect_word(8'h69, 1'b0, 1'b0);
        send_tx(8'h69);
        check(txd_oe, "R11 driver on during frame", 32'(txd_oe), 32'h1);
        wait_ready();
        @(negedge clk);
        check(!txd_oe, "R11 driver released after frame", 32'(txd_oe), 32'h0);
        wait_bits(2);
        expect_word(8'h96, 1'b0, 1'b0);
        send_raw(8'h96, 1'b1);
        wait_bits(2);
        check(exp_q.size() == 0, "R11 both wire frames received", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule